// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

The block timestamps transitions on up to four asynchronous input lines. A free-running counter, advanced by a programmable clock divider, supplies the time base. Each channel carries a 2-bit trigger code that picks which transitions count. When a selected transition arrives, the channel copies the counter into its capture register. If that channel's interrupt enable is set, the channel also sets its pending status bit.

Software reaches the unit through a simple register port. A write strobe carries an address and data, and a separate read address returns data combinationally. A single global enable gates every channel. One acknowledge register clears any chosen subset of the pending bits. The interrupt line is high whenever any pending bit is set. Turning the timestamps into period or duty figures is left to software.

Top module: `icu_capture_unit`

## Requirements
- R1: After reset every register reads zero (control, enables, status, trigger codes, capture values) and `irq` is low.
- R2: Trigger code 1 selects rising transitions only. The trigger register of channel k sits at byte address 0x30+4*k, code in bits 1:0.
- R3: Trigger code 2 selects falling transitions, code 3 selects both directions and code 0 selects none.
- R4: Each input passes two synchronizer flops before edge detection. The capture register of channel k (read at 0x10+4*k, zero-extended) takes the counter value held in the cycle where the synchronized edge is detected, and it changes at no other time.
- R5: A capture sets status bit k only when interrupt-enable bit 1+k of the register at 0x54 is set. The capture value is stored regardless.
- R6: A write to 0x5C clears every status bit whose position (bits 4:1, channel k at bit 1+k) is 1 in the written data. Status is read at 0x58 in the same bit positions.
- R7: When an acknowledge write and a new capture event hit the same channel in the same cycle, that channel's status bit stays set.
- R8: While the global capture enable (control register 0x50, bit 10) is 0, no capture register changes and no status bit is set.
- R9: The 5-bit divider field in bits 8:4 of the control register, value P, makes the counter advance by one every P+1 clock cycles.
- R10: The capture counter is CNT_W bits wide and wraps silently from all-ones to zero.
- R11: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous lines to be timestamped |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | High while any status bit is pending |

## Verification
The assertions assume `rst_n` is held low for at least one rising clock edge. They also assume the register port is driven with settled values at each rising edge. The bench meets this by changing every input, including `cap_in`, on the falling edge only. The asynchronous lines are not toggled faster than the synchronizer can follow: each transition is held for several cycles, so every edge that the reference model expects is one the design can resolve. The acknowledge-versus-capture collision is placed on the exact cycle where the synchronized edge is detected. That cycle is derived by counting the two synchronizer flops from the falling-edge stimulus.

// File: rtl/icu_pkg.sv
package icu_pkg;

   localparam int unsigned ICU_MAX_CH     = 4;

   // byte addresses; the per-channel banks use a 4-byte stride
   localparam int unsigned OFF_CAP_BASE   = 'h10;
   localparam int unsigned OFF_EDGE_BASE  = 'h30;
   localparam int unsigned OFF_CTRL       = 'h50;
   localparam int unsigned OFF_IEN        = 'h54;
   localparam int unsigned OFF_STAT       = 'h58;
   localparam int unsigned OFF_ACK        = 'h5C;

   // bit positions
   localparam int unsigned CTRL_PSC_LSB   = 4;
   localparam int unsigned CTRL_EN_BIT    = 10;
   localparam int unsigned IRQ_LSB        = 1;

   typedef enum logic [1:0] {
      TRIG_NONE = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_ANY  = 2'd3
   } trig_mode_e;

   function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prev);
      logic up;
      logic dn;
      up = cur & ~prev;
      dn = ~cur & prev;
      case (mode)
         TRIG_RISE: return up;
         TRIG_FALL: return dn;
         TRIG_ANY:  return up | dn;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/icu_edge_detect.sv
module icu_edge_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] mode,
   input  logic       gate,
   output logic       hit
);
   import icu_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icu_edge_detect: SYNC_STAGES must be at least 2");
   end

   // stages [SYNC_STAGES-1:0] synchronize, the top stage holds the previous value
   logic [SYNC_STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], din};
   end

   assign hit = gate & trig_hit(trig_mode_e'(mode), pipe_q[SYNC_STAGES-1], pipe_q[SYNC_STAGES]);

endmodule

// File: rtl/icu_timebase.sv
module icu_timebase #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PSC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] psc,
   output logic [CNT_W-1:0] cnt
);
   logic [PSC_W-1:0] div_q;
   logic             tick;

   // ">=" lets a divider lowered below the running count recover at once
   assign tick = (div_q >= psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt   <= '0;
      end else begin
         div_q <= tick ? '0 : div_q + 1'b1;
         cnt   <= cnt + CNT_W'(tick);
      end
   end

endmodule

// File: rtl/icu_chan.sv
module icu_chan #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic             ien,
   input  logic             ack,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap  <= '0;
         stat <= 1'b0;
      end else begin
         if (ev) cap <= cnt;
         // a new event outranks a simultaneous acknowledge
         stat <= (stat & ~ack) | (ev & ien);
      end
   end

endmodule

// File: rtl/icu_capture_unit.sv
module icu_capture_unit #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PSC_W       = 5,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   import icu_pkg::*;

   if (NUM_CH < 1 || NUM_CH > ICU_MAX_CH) begin : g_bad_ch
      $error("icu_capture_unit: NUM_CH out of range");
   end
   if (PSC_W < 1 || PSC_W > 5) begin : g_bad_psc
      $error("icu_capture_unit: PSC_W must fit bits 8:4");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("icu_capture_unit: CNT_W must fit the data path");
   end
   if (DATA_W < CTRL_EN_BIT + 1 || ADDR_W < 7) begin : g_bad_bus
      $error("icu_capture_unit: bus too narrow for the register map");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);

   logic [PSC_W-1:0]        psc_q;
   logic                    cap_en_q;
   logic [NUM_CH-1:0]       ien_q;
   logic [NUM_CH-1:0]       stat_q;
   logic [NUM_CH-1:0]       ev;
   logic [NUM_CH-1:0]       set_req;
   logic [NUM_CH-1:0]       ack_vec;
   logic [CNT_W-1:0]        cnt;
   logic [CNT_W-1:0]        cap   [NUM_CH];
   logic [1:0]              trig_q[NUM_CH];
   logic [NUM_CH*CNT_W-1:0] cap_flat;

   // global registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q    <= '0;
         cap_en_q <= 1'b0;
         ien_q    <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            psc_q    <= wr_data[CTRL_PSC_LSB +: PSC_W];
            cap_en_q <= wr_data[CTRL_EN_BIT];
         end
         if (wr_addr == A_IEN) ien_q <= wr_data[IRQ_LSB +: NUM_CH];
      end
   end

   assign ack_vec = (wr_en && wr_addr == A_ACK) ? wr_data[IRQ_LSB +: NUM_CH] : '0;
   assign set_req = ev & ien_q;

   icu_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
      .clk   (clk),
      .rst_n (rst_n),
      .psc   (psc_q),
      .cnt   (cnt)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFF_EDGE_BASE + 4 * k);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          trig_q[k] <= 2'b00;
         else if (wr_en && wr_addr == A_TRIG) trig_q[k] <= wr_data[1:0];
      end

      icu_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (cap_in[k]),
         .mode  (trig_q[k]),
         .gate  (cap_en_q),
         .hit   (ev[k])
      );

      icu_chan #(.CNT_W(CNT_W)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .ev    (ev[k]),
         .ien   (ien_q[k]),
         .ack   (ack_vec[k]),
         .cnt   (cnt),
         .cap   (cap[k]),
         .stat  (stat_q[k])
      );

      assign cap_flat[k*CNT_W +: CNT_W] = cap[k];
   end

   assign irq = |stat_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[CTRL_PSC_LSB +: PSC_W] = psc_q;
         rd_data[CTRL_EN_BIT]           = cap_en_q;
      end
      if (rd_addr == A_IEN)  rd_data[IRQ_LSB +: NUM_CH] = ien_q;
      if (rd_addr == A_STAT) rd_data[IRQ_LSB +: NUM_CH] = stat_q;
      for (int k = 0; k < NUM_CH; k++) begin
         if (rd_addr == ADDR_W'(OFF_CAP_BASE + 4 * k))  rd_data = DATA_W'(cap[k]);
         if (rd_addr == ADDR_W'(OFF_EDGE_BASE + 4 * k)) rd_data = DATA_W'(trig_q[k]);
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/icu_capture_checker.sv
module icu_capture_checker #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cap_en,
   input logic [NUM_CH-1:0]       status,
   input logic [NUM_CH-1:0]       set_req,
   input logic [NUM_CH-1:0]       ack_vec,
   input logic [NUM_CH-1:0]       ev,
   input logic [CNT_W-1:0]        cnt,
   input logic [NUM_CH*CNT_W-1:0] cap_flat,
   input logic                    irq
);
   a_r8_no_new_status_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ((status & ~$past(status)) == '0));

   a_r7_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req != '0) |=> ((status & $past(set_req)) == $past(set_req)));

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec != '0) |=> ((status & $past(ack_vec & ~set_req)) == '0));

   a_r11_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(set_req) != '0));

   a_r9_counter_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      a_r4_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
         !ev[k] |=> $stable(cap_flat[k*CNT_W +: CNT_W]));

      a_r4_latch_counter: assert property (@(posedge clk) disable iff (!rst_n)
         ev[k] |=> (cap_flat[k*CNT_W +: CNT_W] == $past(cnt)));
   end

endmodule

bind icu_capture_unit icu_capture_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cap_en   (cap_en_q),
   .status   (stat_q),
   .set_req  (set_req),
   .ack_vec  (ack_vec),
   .ev       (ev),
   .cnt      (cnt),
   .cap_flat (cap_flat),
   .irq      (irq)
);

// File: tb/icu_capture_unit_tb.sv
module icu_capture_unit_tb;
   localparam int NCH = 4;
   localparam int CW  = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] sig = '0;
   logic           wr_en = 1'b0;
   logic [7:0]     wr_addr = '0;
   logic [31:0]    wr_data = '0;
   logic [7:0]     rd_addr = 8'h10;
   logic [31:0]    rd_data;
   logic           irq;

   always #4 clk = ~clk;

   icu_capture_unit #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cap_in(sig), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [NCH-1:0] s1, s2, s3;
   logic [1:0]     mtrig [NCH];
   logic [4:0]     mpsc, mdiv;
   logic           men;
   logic [NCH-1:0] mien, mstat;
   logic [CW-1:0]  mcnt;
   logic [CW-1:0]  mcap  [NCH];

   always @(posedge clk) begin : model
      logic [NCH-1:0] evv, ackv;
      logic           tk, up, dn;
      if (!rst_n) begin
         s1 = '0; s2 = '0; s3 = '0; mpsc = '0; mdiv = '0; men = 1'b0;
         mien = '0; mstat = '0; mcnt = '0;
         for (int k = 0; k < NCH; k++) begin mtrig[k] = 2'd0; mcap[k] = '0; end
      end else begin
         for (int k = 0; k < NCH; k++) begin
            up = s2[k] && !s3[k];
            dn = !s2[k] && s3[k];
            evv[k] = men && ((mtrig[k] == 2'd1 && up) || (mtrig[k] == 2'd2 && dn) ||
                             (mtrig[k] == 2'd3 && (up || dn)));
            if (evv[k]) mcap[k] = mcnt;
         end
         ackv  = (wr_en && wr_addr == 8'h5C) ? wr_data[NCH:1] : '0;
         mstat = (mstat & ~ackv) | (evv & mien);
         tk    = (mdiv >= mpsc);
         mcnt  = mcnt + (tk ? 1 : 0);
         mdiv  = tk ? 5'd0 : mdiv + 5'd1;
         if (wr_en) begin
            if (wr_addr == 8'h50) begin mpsc = wr_data[8:4]; men = wr_data[10]; end
            if (wr_addr == 8'h54) mien = wr_data[NCH:1];
            for (int k = 0; k < NCH; k++)
               if (wr_addr == 8'(8'h30 + 4 * k)) mtrig[k] = wr_data[1:0];
         end
         s3 = s2; s2 = s1; s1 = sig;
      end
   end

   function automatic logic [31:0] mread(logic [7:0] a);
      logic [31:0] r;
      r = '0;
      if (a == 8'h50) begin r[8:4] = mpsc; r[10] = men; end
      if (a == 8'h54) r[NCH:1] = mien;
      if (a == 8'h58) r[NCH:1] = mstat;
      for (int k = 0; k < NCH; k++) begin
         if (a == 8'(8'h10 + 4 * k)) r = 32'(mcap[k]);
         if (a == 8'(8'h30 + 4 * k)) r = 32'(mtrig[k]);
      end
      return r;
   endfunction

   function automatic string tag_of(logic [7:0] a);
      if (a < 8'h30)  return "R4 capture value";
      if (a < 8'h50)  return "R2 trigger code";
      if (a == 8'h50) return "R9 control";
      if (a == 8'h54) return "R5 enable";
      return "R6 status";
   endfunction

   // per-cycle comparison, round-robin over the readable registers
   int rr = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R11 irq", 32'(irq), 32'(mstat != '0));
         chk(tag_of(rd_addr), rd_data, mread(rd_addr));
         rr = (rr + 1) % 11;
         if (rr < 4)      rd_addr = 8'(8'h10 + 4 * rr);
         else if (rr < 8) rd_addr = 8'(8'h30 + 4 * (rr - 4));
         else             rd_addr = 8'(8'h50 + 4 * (rr - 8));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rdv(logic [7:0] a, output logic [31:0] v);
      logic [7:0] save;
      @(posedge clk); #2;
      save = rd_addr; rd_addr = a; #1;
      v = rd_data; rd_addr = save;
   endtask

   task automatic peek(logic [7:0] a, logic [31:0] exp, string tag);
      logic [31:0] v;
      rdv(a, v);
      chk(tag, v, exp);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] c1, c2;
      idle(4);
      @(negedge clk) rst_n = 1'b1;

      peek(8'h50, 32'h0, "R1 control after reset");
      peek(8'h58, 32'h0, "R1 status after reset");
      peek(8'h10, 32'h0, "R1 capture after reset");
      peek(8'h30, 32'h0, "R1 trigger after reset");
      chk("R1 irq after reset", 32'(irq), 32'h0);

      wr(8'h54, 32'h1E);
      wr(8'h30, 32'd1); wr(8'h34, 32'd2); wr(8'h38, 32'd3); wr(8'h3C, 32'd0);
      wr(8'h50, 32'h400);

      @(negedge clk) sig = 4'hF;
      idle(5);
      peek(8'h58, 32'h0A, "R2 rising triggers ch0 and ch2 only");
      wr(8'h5C, 32'h1FF);
      peek(8'h58, 32'h00, "R6 ack clears all");

      @(negedge clk) sig = 4'h0;
      idle(5);
      peek(8'h58, 32'h0C, "R3 falling triggers ch1 and ch2, code 0 none");
      chk("R11 irq pending", 32'(irq), 32'h1);
      wr(8'h5C, 32'h04);
      peek(8'h58, 32'h08, "R6 partial ack");
      wr(8'h5C, 32'h1FF);
      chk("R11 irq cleared", 32'(irq), 32'h0);

      // ack lands on the cycle the synchronized edge is detected
      @(negedge clk) sig[0] = 1'b1;
      @(negedge clk);
      @(negedge clk) begin wr_en = 1'b1; wr_addr = 8'h5C; wr_data = 32'h02; end
      @(negedge clk) wr_en = 1'b0;
      peek(8'h58, 32'h02, "R7 event beats ack");
      @(negedge clk) sig[0] = 1'b0;
      wr(8'h5C, 32'h1FF);

      wr(8'h54, 32'h1A);
      @(negedge clk) sig[1] = 1'b1;
      idle(5);
      @(negedge clk) sig[1] = 1'b0;
      idle(5);
      peek(8'h58, 32'h00, "R5 masked channel sets no status");

      wr(8'h54, 32'h1E);
      wr(8'h50, 32'h0);
      @(negedge clk) sig = 4'hF;
      idle(5);
      @(negedge clk) sig = 4'h0;
      idle(5);
      peek(8'h58, 32'h00, "R8 disabled unit sets no status");

      wr(8'h50, 32'h430);
      wr(8'h5C, 32'h1FF);
      @(negedge clk) sig[0] = 1'b1;
      repeat (10) @(negedge clk);
      sig[0] = 1'b0;
      rdv(8'h10, c1);
      repeat (30) @(negedge clk);
      sig[0] = 1'b1;
      idle(5);
      rdv(8'h10, c2);
      chk("R9 divider 4: 40 cycles give 10 counts", c2 - c1, 32'd10);

      wr(8'h50, 32'h400);
      @(negedge clk) sig[0] = 1'b0;
      idle(5);
      @(negedge clk) sig[0] = 1'b1;
      repeat (10) @(negedge clk);
      sig[0] = 1'b0;
      rdv(8'h10, c1);
      repeat (1014) @(negedge clk);
      sig[0] = 1'b1;
      idle(5);
      rdv(8'h10, c2);
      chk("R10 counter wraps after 2**CNT_W counts", c2, c1);

      idle(20);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule